// File: doc/BRIEF.md
# Byte-fed CRC-16 checksum engine

A small register-mapped checksum unit that software drives one value at a time. Each write to the input word folds the low byte of the written value into a running 16-bit CRC and advances a 12-bit count of accepted values. A control word reinitialises both the checksum and the count. Four 16-bit words can be read back: the control word (which carries the count), the input word, the raw running CRC state, and the finished CRC.

The CRC uses the generator x^16 + x^12 + x^5 + 1. Bits are processed least significant first, so the shift register holds the reflected polynomial 0x8408. The state starts at 0xFFFF, and the finished value is the bitwise inverse of the state. With these settings, the four bytes 0xCC, 0xF5, 0xF1, 0xA7 fed after a reinitialise give 0x51DF. Software can use this as a power-on self-test.

The bus is a plain single-cycle register port with no back-pressure. A write takes effect on the clock edge where `wr_en` is high. The read data is a combinational function of `rd_addr` and the current state. A read in the cycle after a write therefore already sees the write's effect.

Top module: `crc_eng`

## Requirements
- R1: After `rst_n` is released, the count reads 0, the raw state (word 2) reads 0xFFFF and the finished CRC (word 3) reads 0x0000.
- R2: Word index map: 0 is control, 1 is input, 2 is raw CRC state, 3 is finished CRC. Word 1 reads as 0x0000.
- R3: A write to word 0 with bit 15 set returns the state to 0xFFFF and the count to 0. A write to word 0 with bit 15 clear changes nothing.
- R4: Each write to word 1 adds one to the count. The new count and CRC are readable in the next cycle.
- R5: Only bits 7:0 of a word-1 write enter the CRC. Bits 15:8 have no effect on the CRC.
- R6: Each accepted byte updates the state least significant bit first, using the reflected polynomial 0x8408. Word 3 returns the bitwise inverse of the state.
- R7: After a reinitialise, feeding 0xCC, 0xF5, 0xF1 and 0xA7 gives a count of 4 and a word-3 value of 0x51DF.
- R8: The count saturates at 0xFFF. Further input writes still update the CRC.
- R9: Writes to words 2 and 3 change nothing.
- R10: Control-word reads return the count in bits 11:0 and zero in bits 15:12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Word index of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Word index of the read |
| rd_data | output | 16 | Read data, combinational from `rd_addr` and state |

## Verification
Every write lands on the clock edge that samples it. Both the count and the CRC are single registers, so their new values are due at `rd_data` one edge after the write, with no further latency. The bench drives each write half a cycle before an edge and updates its own reference model at that edge. It compares `rd_data` on the following falling edge, so each comparison sees exactly the writes issued up to the previous edge. The read address rotates through all four words across cycles, so count, raw state, finished CRC and the zero-reading word are all compared continuously. Explicit checks are added for the self-test value and for saturation.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    W_CTRL  = 2'd0,
    W_INPUT = 2'd1,
    W_STATE = 2'd2,
    W_RESULT = 2'd3
  } word_e;

  localparam int CLR_BIT = 15;

  // Fold one byte into a reflected CRC state, least significant bit first.
  function automatic logic [15:0] fold_byte(input logic [15:0] st,
                                            input logic [7:0] b,
                                            input logic [15:0] poly_r);
    logic [15:0] s;
    s = st ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      if (s[0]) s = (s >> 1) ^ poly_r;
      else      s = s >> 1;
    end
    return s;
  endfunction
endpackage

// File: rtl/crc_eng_decode.sv
module crc_eng_decode
  import crc_eng_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [WORD_W-1:0] state,
  output logic              clr,
  output logic              feed,
  output logic [7:0]        feed_byte,
  output logic [WORD_W-1:0] rd_data
);
  localparam int PAD_W = WORD_W - CNT_W;

  logic unused_hi;
  assign unused_hi = ^wr_data[CLR_BIT-1:8];

  always_comb begin
    clr       = wr_en && (wr_addr == W_CTRL) && wr_data[CLR_BIT];
    feed      = wr_en && (wr_addr == W_INPUT);
    feed_byte = wr_data[7:0];
  end

  always_comb begin
    unique case (word_e'(rd_addr))
      W_CTRL:   rd_data = {{PAD_W{1'b0}}, cnt};
      W_INPUT:  rd_data = '0;
      W_STATE:  rd_data = state;
      W_RESULT: rd_data = ~state;
      default:  rd_data = '0;
    endcase
  end

  // R3 / R4: a single write cannot both reinitialise and feed
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && feed));

  // R10: control read keeps the pad bits at zero
  a_r10_ctrl_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == W_CTRL) |-> (rd_data[WORD_W-1:CNT_W] == '0));
endmodule

// File: rtl/crc_eng_count.sv
module crc_eng_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clr)                       cnt <= '0;
    else if (inc && (cnt != CNT_MAX))   cnt <= cnt + 1'b1;
  end

  a_r3_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1));

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX));

  a_r9_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/crc_eng_lane.sv
module crc_eng_lane
  import crc_eng_pkg::*;
#(
  parameter logic [15:0] POLY_R = 16'h8408,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load,
  input  logic [7:0]  din,
  output logic [15:0] state
);
  logic [15:0] next_fold;

  always_comb next_fold = fold_byte(state, din, POLY_R);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= INIT;
    else if (clr)   state <= INIT;
    else if (load)  state <= next_fold;
  end

  a_r3_state_init: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == INIT));

  a_r9_state_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(state));
endmodule

// File: rtl/crc_eng.sv
module crc_eng
  import crc_eng_pkg::*;
#(
  parameter int          CNT_W  = 12,
  parameter logic [15:0] POLY_R = 16'h8408,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic             clr, feed;
  logic [7:0]       feed_byte;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      state;

  crc_eng_decode #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .state(state),
    .clr(clr), .feed(feed), .feed_byte(feed_byte), .rd_data(rd_data)
  );

  crc_eng_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(feed), .cnt(cnt)
  );

  crc_eng_lane #(.POLY_R(POLY_R), .INIT(INIT)) u_lane (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(feed), .din(feed_byte),
    .state(state)
  );

  // R6: finished value is the inverse of the raw state at the port
  a_r6_result_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == W_RESULT) |-> (rd_data == ~state));
endmodule

// File: tb/tb_crc_eng.sv
module tb_crc_eng;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [15:0] tbl [256];
  logic [15:0] m_state;
  int          m_cnt;
  logic [1:0]  rot = '0;

  always #5 clk = ~clk;

  crc_eng dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
               .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [15:0] expect_word(input logic [1:0] a);
    case (a)
      2'd0: return {4'h0, m_cnt[11:0]};
      2'd1: return 16'h0000;
      2'd2: return m_state;
      default: return ~m_state;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, advance the model at the edge, compare on the falling edge
  task automatic step(input string tag, input logic we, input logic [1:0] wa,
                      input logic [15:0] wd);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = rot;
    @(posedge clk);
    if (we) begin
      if (wa == 2'd0 && wd[15]) begin
        m_state = 16'hFFFF; m_cnt = 0;
      end else if (wa == 2'd1) begin
        m_state = (m_state >> 8) ^ tbl[(m_state[7:0] ^ wd[7:0])];
        if (m_cnt < 4095) m_cnt++;
      end
    end
    @(negedge clk);
    check(tag, rd_data, expect_word(rot));
    rot = rot + 2'd1;
    wr_en = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      check(tag, rd_data, expect_word(2'(a)));
    end
  endtask

  initial begin
    for (int v = 0; v < 256; v++) begin
      logic [15:0] r;
      r = 16'(v);
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      tbl[v] = r;
    end
    m_state = 16'hFFFF; m_cnt = 0;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 map, R10 pad bits
    read_all("R1 reset");
    rd_addr = 2'd3; #1; check("R1 result zero", rd_data, 16'h0000);
    rd_addr = 2'd2; #1; check("R1 state init", rd_data, 16'hFFFF);

    // R7 self-test vector, R6 algorithm
    step("R3 clear", 1'b1, 2'd0, 16'h8000);
    step("R7 b0", 1'b1, 2'd1, 16'h00CC);
    step("R7 b1", 1'b1, 2'd1, 16'h00F5);
    step("R7 b2", 1'b1, 2'd1, 16'h00F1);
    step("R7 b3", 1'b1, 2'd1, 16'h00A7);
    rd_addr = 2'd3; #1; check("R7 self-test crc", rd_data, 16'h51DF);
    rd_addr = 2'd0; #1; check("R7 self-test count", rd_data, 16'h0004);

    // R4 next-cycle visibility, R6 with varied bytes
    lf = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      step("R4 R6 stream", 1'b1, 2'd1, {8'h00, lf[7:0]});
    end
    // R5 upper bits ignored in the checksum
    for (int i = 0; i < 24; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      step("R5 high bits", 1'b1, 2'd1, lf[15:0] | 16'hF00);
    end
    // R3 control write without bit 15; R9 writes to read-only words
    step("R3 no clear", 1'b1, 2'd0, 16'h7FFF);
    step("R9 word2", 1'b1, 2'd2, 16'h1234);
    step("R9 word3", 1'b1, 2'd3, 16'hABCD);
    read_all("R9 R3 unchanged");
    // idle cycles compared every clock
    for (int i = 0; i < 8; i++) step("R2 idle", 1'b0, 2'd1, 16'h00FF);
    // R3 mid-stream reinitialise then fresh vector
    step("R3 reinit", 1'b1, 2'd0, 16'hFFFF);
    read_all("R3 after reinit");
    step("R6 one", 1'b1, 2'd1, 16'h0031);
    read_all("R6 single byte");

    // R8 saturation
    step("R3 clear", 1'b1, 2'd0, 16'h8000);
    for (int i = 0; i < 4100; i++) step("R8 fill", 1'b1, 2'd1, 16'(i));
    rd_addr = 2'd0; #1; check("R8 saturated", rd_data, 16'h0FFF);
    read_all("R8 crc still moving");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule